// File: doc/BRIEF.md
# CPU Exception Entry Controller

This block makes the architectural state change that happens when a processor core takes an exception or an interrupt. The core presents its current program counter, status word, power-management word, a flag that marks an instruction in a branch delay slot, and a cause code, then raises an entry strobe. On one clock edge the block does four things. It records the return address, the faulting address for an illegal instruction and the pre-entry status word. It writes a rewritten status word and power-management word. It drops any load-linked reservation. It computes the handler address that the core must load as its next program counter.

Two asynchronous interrupt sources, an external device line and a tick timer, are arbitrated in the same block. Each one is taken only when its own enable bit in the incoming status word is set. An explicit entry strobe takes precedence over both. The cycle after an entry, the block drives a one-cycle acknowledge with all results valid. The core is expected to copy the new status word and program counter during that cycle, and the block accepts no new entry while the acknowledge is high. A cause code outside the valid range produces a one-cycle abort pulse and no state change.

Top module: `exc_entry_ctrl`

## Requirements
- R1: On an accepted entry `ret_pc_o` becomes `pc_i`, or `pc_i`+4 when the cause is system call (code 12); cause codes are reset 1, bus error 2, data page fault 3, instruction page fault 4, tick 5, alignment 6, illegal 7, external interrupt 8, data TLB miss 9, instruction TLB miss 10, range 11, system call 12, floating point 13, trap 14.
- R2: `fault_addr_o` is loaded with `pc_i` only when an accepted entry has cause 7 (illegal); any other entry leaves it unchanged.
- R3: `saved_sr_o` receives the value of `sr_i` sampled at the entry edge.
- R4: `sr_o` equals `sr_i` with bits 1 (tick enable), 2 (interrupt enable), 5 (data MMU enable) and 6 (instruction MMU enable) cleared, bit 0 (supervisor) set, and bit 13 set per R6; `pwr_o` equals `pwr_i` with bits 4 and 5 cleared. All other bits are preserved.
- R5: `resv_o` becomes all ones after every accepted entry.
- R6: When `dslot_i` is high, `ret_pc_o` is reduced by 4 after the R1 adjustment, `sr_o` bit 13 is set and `dslot_clr_o` pulses with the acknowledge; otherwise bit 13 is cleared and `dslot_clr_o` stays low.
- R7: `pc_o` is the cause code shifted left by 8, OR'd with `vec_base_i` when `vec_base_en_i` is high, and OR'd with 0xF0000000 when `sr_i` bit 14 is set.
- R8: An entry strobe whose cause is 0 or 15 pulses `abort_o` for one cycle, does not raise `ack_o`, and leaves every saved output unchanged.
- R9: Without an entry strobe, `tick_irq_i` is taken as cause 5 when `sr_i` bit 1 is set and `ext_irq_i` as cause 8 when `sr_i` bit 2 is set; when both are eligible the tick wins; an ineligible request is ignored; an entry strobe takes precedence over both.
- R10: `ack_o` is high for exactly the one cycle after an accepted entry, and no entry or interrupt is accepted in that cycle.
- R11: After synchronous reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| entry_i | input | 1 | Request to enter the handler for `cause_i` |
| cause_i | input | 4 | Cause code of the synchronous exception |
| pc_i | input | 32 | Current program counter |
| sr_i | input | 32 | Current status word |
| dslot_i | input | 1 | Current instruction sits in a delay slot |
| pwr_i | input | 32 | Current power-management word |
| vec_base_en_i | input | 1 | Configuration: vector base register present |
| vec_base_i | input | 32 | Vector base register |
| ext_irq_i | input | 1 | External device interrupt request |
| tick_irq_i | input | 1 | Tick timer interrupt request |
| ack_o | output | 1 | Entry taken, results valid this cycle |
| abort_o | output | 1 | Entry refused for an invalid cause |
| ret_pc_o | output | 32 | Saved return address |
| fault_addr_o | output | 32 | Saved effective address |
| saved_sr_o | output | 32 | Saved pre-entry status word |
| sr_o | output | 32 | Rewritten status word |
| pwr_o | output | 32 | Rewritten power-management word |
| pc_o | output | 32 | Handler address |
| resv_o | output | 32 | Load-linked reservation address |
| dslot_clr_o | output | 1 | Delay-slot flag must be cleared |

## Verification
The hardest situation to reach is an interrupt request that stays asserted across the acknowledge cycle with its enable bit unchanged, because the core normally removes the enable by loading the new status word. The stimulus holds an external request and its enable for three edges and expects two entries with a quiet cycle between them. Each cause is also driven both inside and outside a delay slot, and system call in a delay slot is included because the two address adjustments cancel.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int XLEN       = 32;
    localparam int CAUSE_W    = 4;
    localparam int WORD_BYTES = XLEN / 8;

    typedef logic [XLEN-1:0]    word_t;
    typedef logic [CAUSE_W-1:0] cause_t;

    // Cause codes; the numeric value positions the handler vector.
    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE     = 4'd0,
        CAUSE_RESET    = 4'd1,
        CAUSE_BUSERR   = 4'd2,
        CAUSE_DPAGE    = 4'd3,
        CAUSE_IPAGE    = 4'd4,
        CAUSE_TICK     = 4'd5,
        CAUSE_ALIGN    = 4'd6,
        CAUSE_ILLEGAL  = 4'd7,
        CAUSE_EXTINT   = 4'd8,
        CAUSE_DTLB     = 4'd9,
        CAUSE_ITLB     = 4'd10,
        CAUSE_RANGE    = 4'd11,
        CAUSE_SYSCALL  = 4'd12,
        CAUSE_FPU      = 4'd13,
        CAUSE_TRAP     = 4'd14
    } cause_e;

    // Status word bit positions.
    localparam int SR_SUPER   = 0;
    localparam int SR_TICK_EN = 1;
    localparam int SR_IRQ_EN  = 2;
    localparam int SR_DMMU_EN = 5;
    localparam int SR_IMMU_EN = 6;
    localparam int SR_IN_DSL  = 13;
    localparam int SR_HIVEC   = 14;

    // Power-management word bit positions.
    localparam int PW_DOZE    = 4;
    localparam int PW_SLEEP   = 5;

    // Everything written on one entry edge.
    typedef struct packed {
        word_t  ret_pc;
        logic   fault_we;
        word_t  fault_addr;
        word_t  saved_sr;
        word_t  sr;
        word_t  pwr;
        word_t  vec;
        logic   dslot;
    } entry_upd_t;

    function automatic logic cause_in_range(input cause_t c, input int n_cause);
        return (c != CAUSE_NONE) && (int'(c) < n_cause);
    endfunction

    function automatic word_t bit_mask(input int pos);
        return word_t'(1) << pos;
    endfunction

endpackage

// File: rtl/exc_source_arb.sv
module exc_source_arb
    import exc_entry_pkg::*;
#(
    parameter int N_CAUSE = 15
) (
    input  logic   busy_i,
    input  logic   entry_i,
    input  cause_t cause_i,
    input  logic   ext_irq_i,
    input  logic   tick_irq_i,
    input  logic   irq_en_i,
    input  logic   tick_en_i,
    output logic   take_o,
    output logic   abort_o,
    output cause_t cause_o
);

    logic tick_ok;
    logic ext_ok;

    assign tick_ok = tick_irq_i && tick_en_i;
    assign ext_ok  = ext_irq_i  && irq_en_i;

    always_comb begin
        take_o  = 1'b0;
        abort_o = 1'b0;
        cause_o = cause_i;
        if (!busy_i) begin
            if (entry_i) begin
                if (cause_in_range(cause_i, N_CAUSE)) begin
                    take_o = 1'b1;
                end else begin
                    abort_o = 1'b1;
                end
            end else if (tick_ok) begin
                take_o  = 1'b1;
                cause_o = CAUSE_TICK;
            end else if (ext_ok) begin
                take_o  = 1'b1;
                cause_o = CAUSE_EXTINT;
            end
        end
    end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
    import exc_entry_pkg::*;
#(
    parameter int    VEC_SHIFT = 8,
    parameter word_t HIGH_VEC  = 32'hF000_0000
) (
    input  cause_t cause_i,
    input  logic   base_en_i,
    input  word_t  base_i,
    input  logic   high_i,
    output word_t  vec_o
);

    word_t offset;

    assign offset = word_t'(cause_i) << VEC_SHIFT;

    always_comb begin
        vec_o = offset;
        if (base_en_i) begin
            vec_o = vec_o | base_i;
        end
        if (high_i) begin
            vec_o = vec_o | HIGH_VEC;
        end
    end

endmodule

// File: rtl/exc_status_rewrite.sv
module exc_status_rewrite
    import exc_entry_pkg::*;
(
    input  word_t  sr_i,
    input  word_t  pwr_i,
    input  logic   dslot_i,
    output word_t  sr_o,
    output word_t  pwr_o
);

    localparam word_t SR_CLR = bit_mask(SR_TICK_EN) | bit_mask(SR_IRQ_EN)
                             | bit_mask(SR_DMMU_EN) | bit_mask(SR_IMMU_EN)
                             | bit_mask(SR_IN_DSL);
    localparam word_t PW_CLR = bit_mask(PW_DOZE) | bit_mask(PW_SLEEP);

    always_comb begin
        sr_o = (sr_i & ~SR_CLR) | bit_mask(SR_SUPER);
        if (dslot_i) begin
            sr_o = sr_o | bit_mask(SR_IN_DSL);
        end
        pwr_o = pwr_i & ~PW_CLR;
    end

endmodule

// File: rtl/exc_save_regs.sv
module exc_save_regs
    import exc_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       take_i,
    input  logic       abort_i,
    input  entry_upd_t upd_i,
    output logic       ack_o,
    output logic       abort_o,
    output word_t      ret_pc_o,
    output word_t      fault_addr_o,
    output word_t      saved_sr_o,
    output word_t      sr_o,
    output word_t      pwr_o,
    output word_t      pc_o,
    output word_t      resv_o,
    output logic       dslot_clr_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_o        <= 1'b0;
            abort_o      <= 1'b0;
            ret_pc_o     <= '0;
            fault_addr_o <= '0;
            saved_sr_o   <= '0;
            sr_o         <= '0;
            pwr_o        <= '0;
            pc_o         <= '0;
            resv_o       <= '0;
            dslot_clr_o  <= 1'b0;
        end else begin
            ack_o       <= take_i;
            abort_o     <= abort_i;
            dslot_clr_o <= take_i && upd_i.dslot;
            if (take_i) begin
                ret_pc_o   <= upd_i.ret_pc;
                saved_sr_o <= upd_i.saved_sr;
                sr_o       <= upd_i.sr;
                pwr_o      <= upd_i.pwr;
                pc_o       <= upd_i.vec;
                resv_o     <= '1;
                if (upd_i.fault_we) begin
                    fault_addr_o <= upd_i.fault_addr;
                end
            end
        end
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int    N_CAUSE   = 15,
    parameter int    VEC_SHIFT = 8,
    parameter word_t HIGH_VEC  = 32'hF000_0000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                entry_i,
    input  logic [CAUSE_W-1:0]  cause_i,
    input  logic [XLEN-1:0]     pc_i,
    input  logic [XLEN-1:0]     sr_i,
    input  logic                dslot_i,
    input  logic [XLEN-1:0]     pwr_i,
    input  logic                vec_base_en_i,
    input  logic [XLEN-1:0]     vec_base_i,
    input  logic                ext_irq_i,
    input  logic                tick_irq_i,
    output logic                ack_o,
    output logic                abort_o,
    output logic [XLEN-1:0]     ret_pc_o,
    output logic [XLEN-1:0]     fault_addr_o,
    output logic [XLEN-1:0]     saved_sr_o,
    output logic [XLEN-1:0]     sr_o,
    output logic [XLEN-1:0]     pwr_o,
    output logic [XLEN-1:0]     pc_o,
    output logic [XLEN-1:0]     resv_o,
    output logic                dslot_clr_o
);

    localparam word_t STEP = word_t'(WORD_BYTES);

    logic       take;
    logic       abort_req;
    cause_t     sel_cause;
    word_t      vec;
    word_t      new_sr;
    word_t      new_pwr;
    word_t      ret_pc;
    entry_upd_t upd;

    exc_source_arb #(.N_CAUSE(N_CAUSE)) u_arb (
        .busy_i     (ack_o),
        .entry_i    (entry_i),
        .cause_i    (cause_i),
        .ext_irq_i  (ext_irq_i),
        .tick_irq_i (tick_irq_i),
        .irq_en_i   (sr_i[SR_IRQ_EN]),
        .tick_en_i  (sr_i[SR_TICK_EN]),
        .take_o     (take),
        .abort_o    (abort_req),
        .cause_o    (sel_cause)
    );

    exc_vector_gen #(.VEC_SHIFT(VEC_SHIFT), .HIGH_VEC(HIGH_VEC)) u_vec (
        .cause_i   (sel_cause),
        .base_en_i (vec_base_en_i),
        .base_i    (vec_base_i),
        .high_i    (sr_i[SR_HIVEC]),
        .vec_o     (vec)
    );

    exc_status_rewrite u_sr (
        .sr_i    (sr_i),
        .pwr_i   (pwr_i),
        .dslot_i (dslot_i),
        .sr_o    (new_sr),
        .pwr_o   (new_pwr)
    );

    // Return address: one word forward past a system call, one word back
    // to the branch owning a delay slot.
    always_comb begin
        ret_pc = pc_i;
        if (sel_cause == CAUSE_SYSCALL) begin
            ret_pc = ret_pc + STEP;
        end
        if (dslot_i) begin
            ret_pc = ret_pc - STEP;
        end
    end

    always_comb begin
        upd.ret_pc     = ret_pc;
        upd.fault_we   = (sel_cause == CAUSE_ILLEGAL);
        upd.fault_addr = pc_i;
        upd.saved_sr   = sr_i;
        upd.sr         = new_sr;
        upd.pwr        = new_pwr;
        upd.vec        = vec;
        upd.dslot      = dslot_i;
    end

    exc_save_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .take_i       (take),
        .abort_i      (abort_req),
        .upd_i        (upd),
        .ack_o        (ack_o),
        .abort_o      (abort_o),
        .ret_pc_o     (ret_pc_o),
        .fault_addr_o (fault_addr_o),
        .saved_sr_o   (saved_sr_o),
        .sr_o         (sr_o),
        .pwr_o        (pwr_o),
        .pc_o         (pc_o),
        .resv_o       (resv_o),
        .dslot_clr_o  (dslot_clr_o)
    );

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             entry_i,
    input logic [CAUSE_W-1:0] cause_i,
    input logic [XLEN-1:0]  sr_i,
    input logic             vec_base_en_i,
    input logic             tick_irq_i,
    input logic             ack_o,
    input logic             abort_o,
    input logic [XLEN-1:0]  ret_pc_o,
    input logic [XLEN-1:0]  fault_addr_o,
    input logic [XLEN-1:0]  saved_sr_o,
    input logic [XLEN-1:0]  sr_o,
    input logic [XLEN-1:0]  pwr_o,
    input logic [XLEN-1:0]  pc_o,
    input logic [XLEN-1:0]  resv_o,
    input logic             dslot_clr_o
);

    logic good_entry;
    assign good_entry = entry_i && !ack_o && (cause_i != 4'd0) && (cause_i != 4'd15);

    p_ack_after_entry_r10: assert property (@(posedge clk) disable iff (rst)
        good_entry |=> ack_o);

    p_ack_single_r10: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o);

    p_saved_sr_r3: assert property (@(posedge clk) disable iff (rst)
        good_entry |=> saved_sr_o == $past(sr_i));

    p_sr_rewrite_r4: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> (sr_o[0] && !sr_o[1] && !sr_o[2] && !sr_o[5] && !sr_o[6]
                   && !pwr_o[4] && !pwr_o[5]));

    p_resv_drop_r5: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> resv_o == '1);

    p_dslot_flag_r6: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> sr_o[13] == dslot_clr_o);

    p_abort_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(ack_o && abort_o));

    p_abort_hold_r8: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> ($stable(ret_pc_o) && $stable(fault_addr_o) && $stable(pc_o)
                     && $stable(saved_sr_o)));

    p_tick_vec_r9: assert property (@(posedge clk) disable iff (rst)
        (!entry_i && !ack_o && tick_irq_i && sr_i[1] && !sr_i[14] && !vec_base_en_i)
        |=> (ack_o && pc_o == 32'h0000_0500));

endmodule

bind exc_entry_ctrl exc_entry_chk u_chk (.*);

// File: tb/exc_entry_ctrl_bench.sv
`timescale 1ns/1ps
module exc_entry_ctrl_bench;

    typedef struct {
        logic        is_abort;
        logic [31:0] ret_pc;
        logic [31:0] fault;
        logic [31:0] ssr;
        logic [31:0] sr;
        logic [31:0] pwr;
        logic [31:0] pc;
        logic [31:0] resv;
        logic        dclr;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic entry_i = 1'b0;
    logic [3:0]  cause_i = '0;
    logic [31:0] pc_i = '0, sr_i = '0, pwr_i = '0, vec_base_i = '0;
    logic dslot_i = 1'b0, vec_base_en_i = 1'b0, ext_irq_i = 1'b0, tick_irq_i = 1'b0;
    logic ack_o, abort_o, dslot_clr_o;
    logic [31:0] ret_pc_o, fault_addr_o, saved_sr_o, sr_o, pwr_o, pc_o, resv_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t q[$];
    exp_t cur;

    always #2.5 clk = ~clk;

    exc_entry_ctrl u_exc_entry_ctrl (
        .clk(clk), .rst(rst), .entry_i(entry_i), .cause_i(cause_i),
        .pc_i(pc_i), .sr_i(sr_i), .dslot_i(dslot_i), .pwr_i(pwr_i),
        .vec_base_en_i(vec_base_en_i), .vec_base_i(vec_base_i),
        .ext_irq_i(ext_irq_i), .tick_irq_i(tick_irq_i),
        .ack_o(ack_o), .abort_o(abort_o), .ret_pc_o(ret_pc_o),
        .fault_addr_o(fault_addr_o), .saved_sr_o(saved_sr_o), .sr_o(sr_o),
        .pwr_o(pwr_o), .pc_o(pc_o), .resv_o(resv_o), .dslot_clr_o(dslot_clr_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected result of a taken entry, from the requirements.
    function automatic exp_t model(input logic [3:0] c);
        exp_t e;
        e.is_abort = 1'b0;
        e.ret_pc = pc_i + ((c == 4'd12) ? 32'd4 : 32'd0) - (dslot_i ? 32'd4 : 32'd0);
        e.fault  = (c == 4'd7) ? pc_i : cur.fault;
        e.ssr    = sr_i;
        e.sr     = (sr_i & ~32'h0000_2066) | 32'h1 | (dslot_i ? 32'h2000 : 32'h0);
        e.pwr    = pwr_i & ~32'h30;
        e.pc     = ({28'd0, c} << 8) | (vec_base_en_i ? vec_base_i : 32'h0)
                 | (sr_i[14] ? 32'hF000_0000 : 32'h0);
        e.resv   = 32'hFFFF_FFFF;
        e.dclr   = dslot_i;
        return e;
    endfunction

    task automatic push_take(input logic [3:0] c);
        exp_t e;
        e = model(c);
        cur = e;
        q.push_back(e);
    endtask

    task automatic push_abort();
        exp_t e;
        e = cur;
        e.is_abort = 1'b1;
        e.dclr = 1'b0;
        q.push_back(e);
    endtask

    task automatic set_ctx(input logic [31:0] pc, input logic [31:0] sr, input logic ds,
                           input logic [31:0] pw, input logic vben, input logic [31:0] vb);
        pc_i = pc; sr_i = sr; dslot_i = ds; pwr_i = pw; vec_base_en_i = vben; vec_base_i = vb;
    endtask

    // Synchronous entry: one cycle strobe, then the ack cycle with inputs idle.
    task automatic do_entry(input logic [3:0] c);
        @(negedge clk);
        entry_i = 1'b1;
        cause_i = c;
        if (c == 4'd0 || c == 4'd15) push_abort();
        else push_take(c);
        @(negedge clk);
        entry_i = 1'b0;
    endtask

    // Interrupt request for one cycle; exp_c 0 means nothing may be taken.
    task automatic do_irq(input logic ext, input logic tick, input logic [3:0] exp_c);
        @(negedge clk);
        ext_irq_i = ext;
        tick_irq_i = tick;
        if (exp_c != 4'd0) push_take(exp_c);
        @(negedge clk);
        ext_irq_i = 1'b0;
        tick_irq_i = 1'b0;
        if (exp_c == 4'd0)
            chk(!ack_o && !abort_o, "R9 ineligible request ignored", {30'd0, ack_o, abort_o}, 32'd0);
    endtask

    // Monitor: pop and compare on every acknowledge or abort.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && (ack_o || abort_o)) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R10 unexpected ack/abort", {30'd0, ack_o, abort_o}, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(abort_o == e.is_abort && ack_o == !e.is_abort, "R8 ack/abort kind",
                        {30'd0, ack_o, abort_o}, {30'd0, !e.is_abort, e.is_abort});
                    chk(ret_pc_o == e.ret_pc, "R1/R6 return address", ret_pc_o, e.ret_pc);
                    chk(fault_addr_o == e.fault, "R2 fault address", fault_addr_o, e.fault);
                    chk(saved_sr_o == e.ssr, "R3 saved status", saved_sr_o, e.ssr);
                    chk(sr_o == e.sr, "R4/R6 new status", sr_o, e.sr);
                    chk(pwr_o == e.pwr, "R4 power word", pwr_o, e.pwr);
                    chk(pc_o == e.pc, "R7 handler vector", pc_o, e.pc);
                    chk(resv_o == e.resv, "R5 reservation", resv_o, e.resv);
                    chk(dslot_clr_o == e.dclr, "R6 delay flag clear", {31'd0, dslot_clr_o}, {31'd0, e.dclr});
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        cur = '{is_abort: 1'b0, ret_pc: 32'd0, fault: 32'd0, ssr: 32'd0, sr: 32'd0,
                pwr: 32'd0, pc: 32'd0, resv: 32'd0, dclr: 1'b0};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(!ack_o && !abort_o && !dslot_clr_o, "R11 reset flags", {29'd0, ack_o, abort_o, dslot_clr_o}, 32'd0);
        chk(ret_pc_o == 0 && fault_addr_o == 0 && saved_sr_o == 0, "R11 reset saved regs", ret_pc_o | fault_addr_o | saved_sr_o, 32'd0);
        chk(sr_o == 0 && pwr_o == 0 && pc_o == 0 && resv_o == 0, "R11 reset state regs", sr_o | pwr_o | pc_o | resv_o, 32'd0);

        // R1 R2 R3 R4 R5 R7: every cause outside a delay slot, then inside one (R6)
        for (int ds = 0; ds < 2; ds++) begin
            for (int c = 1; c < 15; c++) begin
                set_ctx(32'h0000_1000 + 32'(c) * 32'h40 + 32'(ds) * 32'h10_0000,
                        32'h0000_8067 ^ (32'(c) << 16) | ((c % 3 == 0) ? 32'h4000 : 32'h0),
                        ds[0], 32'h0000_00F3 | (32'(c) << 8),
                        (c % 2) == 1, 32'h0012_0000 + (32'(c) << 20));
                do_entry(4'(c));
            end
        end

        // R6 with R1: system call in a delay slot cancels to pc
        set_ctx(32'h0040_0200, 32'h0000_0006, 1'b1, 32'h30, 1'b0, 32'h0);
        do_entry(4'd12);
        // R2: non-illegal cause keeps fault address
        set_ctx(32'h0055_5500, 32'h0000_0000, 1'b0, 32'h0, 1'b1, 32'hABC0_0000);
        do_entry(4'd3);

        // R8: invalid causes abort, state unchanged
        set_ctx(32'h0777_7770, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF);
        do_entry(4'd0);
        do_entry(4'd15);

        // R9: interrupt eligibility and priority
        set_ctx(32'h0000_8000, 32'h0000_0004, 1'b0, 32'h0, 1'b0, 32'h0);
        do_irq(1'b1, 1'b0, 4'd8);          // external, enabled
        do_irq(1'b0, 1'b1, 4'd0);          // tick, not enabled
        set_ctx(32'h0000_8100, 32'h0000_0002, 1'b0, 32'h0, 1'b0, 32'h0);
        do_irq(1'b1, 1'b0, 4'd0);          // external, not enabled
        do_irq(1'b0, 1'b1, 4'd5);          // tick, enabled
        set_ctx(32'h0000_8200, 32'h0000_4006, 1'b1, 32'h0, 1'b1, 32'h0030_0000);
        do_irq(1'b1, 1'b1, 4'd5);          // both eligible: tick wins
        set_ctx(32'h0000_8300, 32'h0000_0006, 1'b0, 32'h0, 1'b0, 32'h0);
        @(negedge clk);                    // R9: entry strobe beats the tick
        entry_i = 1'b1; cause_i = 4'd7; tick_irq_i = 1'b1;
        push_take(4'd7);
        @(negedge clk);
        entry_i = 1'b0; tick_irq_i = 1'b0;

        // R10: a held request is refused during the ack cycle
        set_ctx(32'h0000_9000, 32'h0000_0004, 1'b0, 32'h5, 1'b0, 32'h0);
        @(negedge clk);
        ext_irq_i = 1'b1;
        push_take(4'd8);
        push_take(4'd8);
        @(negedge clk);
        @(negedge clk);
        chk(!ack_o, "R10 no entry during ack cycle", {31'd0, ack_o}, 32'd0);
        @(negedge clk);
        ext_irq_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(q.size() == 0, "R10 all expected entries seen", 32'(q.size()), 32'd0);
        finish_run();
    end

endmodule